// File: doc/BRIEF.md
# Two-Bank Bus Exchange Latch

This block joins one narrow port, A, to two banks of the same width, B1 and B2, through four storage latches. Towards A, each bank has its own latch, and a bank select chooses which latched bank reaches A. Towards the banks, A feeds two separate latches, one per bank. This lets a single bus be split into two banks, for example with addresses captured into one bank and data into the other, or lets two banks be merged back onto one bus.

Each port has its own active-low drive request. Each bidirectional pin is split into an input, an output value and an output-enable. Storage is synchronous. While a latch enable is high, its output follows its input with no delay, and the register takes the input at every rising clock edge. While the enable is low, the output shows the value taken at the last edge at which the enable was high. If the A port and a B port are asked to drive at the same time, the block raises a clash flag and outputs unknown data instead of choosing a winner.

Top module: `bx_exchange`

## Requirements
- R1: While `rst_n` is low, all three output-enables and `clash` are low and every latch is cleared. After reset, a latch whose enable has stayed low reads zero.
- R2: Each latch is transparent while its enable is 1: its output equals its input in the same cycle. While the enable is 0, the output holds the input sampled at the last rising edge at which the enable was 1, even if the input keeps changing.
- R3: `a_out` shows the B1-side latch (input `b1_in`, enable `le1b`) when `sel` is 1. It shows the B2-side latch (input `b2_in`, enable `le2b`) when `sel` is 0.
- R4: `b1_out` comes from a latch on `a_in` enabled by `lea1b`, and `b2_out` comes from a second latch on `a_in` enabled by `lea2b`. Either enable leaves the other latch unchanged.
- R5: The drive requests are active low: `a_oe` = not `oea_n`, `b1_oe` = not `oe1b_n`, and `b2_oe` = not `oe2b_n`.
- R6: The two B drive requests are independent: neither bank, either bank alone, or both banks may drive.
- R7: When `oea_n` is 0 and at least one of `oe1b_n` or `oe2b_n` is 0, `clash` is 1, and the data on every output is unknown. Otherwise `clash` is 0.
- R8: The drive requests have no effect on storage. A value held through a period with outputs disabled is read back unchanged once the output is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bank select towards A (1 = B1 side) |
| le1b | input | 1 | Enable of the B1-to-A latch |
| le2b | input | 1 | Enable of the B2-to-A latch |
| lea1b | input | 1 | Enable of the A-to-B1 latch |
| lea2b | input | 1 | Enable of the A-to-B2 latch |
| oea_n | input | 1 | A drive request, active low |
| oe1b_n | input | 1 | B1 drive request, active low |
| oe2b_n | input | 1 | B2 drive request, active low |
| a_in | input | W | Value seen on the A pins |
| a_out | output | W | Value driven onto A |
| a_oe | output | 1 | A output-enable |
| b1_in | input | W | Value seen on the B1 pins |
| b1_out | output | W | Value driven onto B1 |
| b1_oe | output | 1 | B1 output-enable |
| b2_in | input | W | Value seen on the B2 pins |
| b2_out | output | W | Value driven onto B2 |
| b2_oe | output | 1 | B2 output-enable |
| clash | output | 1 | Both directions requested at once |

## Verification
The assertions assume that every input changes only between clock edges and stays steady across each rising edge. This keeps the sampled hold value of a latch well defined. They also assume that reset is held for at least one edge, so every stored value is defined before any hold is checked. The bench drives all inputs on the falling edge and compares the outputs in the middle of the low phase. While random stimulus runs, it also keeps the B requests mostly off while A is requested, so that clashes are deliberate and rare.

// File: rtl/bx_pkg.sv
package bx_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_B2A   = 2'd1,
    DIR_A2B   = 2'd2,
    DIR_CLASH = 2'd3
  } bx_dir_e;

  typedef struct packed {
    logic a;
    logic b1;
    logic b2;
  } bx_drive_t;

  // Turn active-low requests into active-high drives, gated by reset.
  function automatic bx_drive_t bx_decode(input logic rst_n, input logic oea_n,
                                          input logic oe1b_n, input logic oe2b_n);
    bx_drive_t r;
    r.a  = rst_n & ~oea_n;
    r.b1 = rst_n & ~oe1b_n;
    r.b2 = rst_n & ~oe2b_n;
    return r;
  endfunction

  function automatic bx_dir_e bx_direction(input bx_drive_t d);
    if (d.a && (d.b1 || d.b2)) return DIR_CLASH;
    if (d.a)                   return DIR_B2A;
    if (d.b1 || d.b2)          return DIR_A2B;
    return DIR_IDLE;
  endfunction

endpackage

// File: rtl/bx_latch.sv
module bx_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= d;
  end

  assign q = le ? d : held;

  // R2: a closed latch keeps its output across consecutive edges
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le) && $past(rst_n)) |-> $stable(q));

  // R2: on closing, the output is the value sampled at the last open edge
  assert_close_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(le) && !le && $past(rst_n)) |-> (q == $past(d)));

endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         le1b,
  input  logic         le2b,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] a_val
);

  logic [W-1:0] from_b1;
  logic [W-1:0] from_b2;

  bx_latch #(.W(W)) u_lat_b1 (
    .clk(clk), .rst_n(rst_n), .le(le1b), .d(b1_in), .q(from_b1)
  );

  bx_latch #(.W(W)) u_lat_b2 (
    .clk(clk), .rst_n(rst_n), .le(le2b), .d(b2_in), .q(from_b2)
  );

  assign a_val = sel ? from_b1 : from_b2;

  // R3: with B1 selected and its latch open, A follows the B1 pins
  assert_sel_b1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && le1b) |-> (a_val == b1_in));

  // R3: with B2 selected and its latch open, A follows the B2 pins
  assert_sel_b2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && le2b) |-> (a_val == b2_in));

endmodule

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lea1b,
  input  logic         lea2b,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] b1_val,
  output logic [W-1:0] b2_val
);

  bx_latch #(.W(W)) u_lat_a1 (
    .clk(clk), .rst_n(rst_n), .le(lea1b), .d(a_in), .q(b1_val)
  );

  bx_latch #(.W(W)) u_lat_a2 (
    .clk(clk), .rst_n(rst_n), .le(lea2b), .d(a_in), .q(b2_val)
  );

  // R4: the B2 latch is untouched while only the B1 latch is open
  assert_bank_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lea1b && !lea2b && $past(!lea2b) && $past(rst_n)) |-> $stable(b2_val));

endmodule

// File: rtl/bx_oe_ctrl.sv
module bx_oe_ctrl
  import bx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oea_n,
  input  logic      oe1b_n,
  input  logic      oe2b_n,
  output bx_drive_t drive,
  output bx_dir_e   dir
);

  assign drive = bx_decode(rst_n, oea_n, oe1b_n, oe2b_n);
  assign dir   = bx_direction(drive);

  // R1: nothing drives while reset is held
  assert_reset_float_R1: assert property (@(posedge clk)
    !rst_n |-> (drive == '0 && dir == DIR_IDLE));

  // R7: both directions requested must be classed as a clash
  assert_clash_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oea_n && (!oe1b_n || !oe2b_n)) |-> (dir == DIR_CLASH));

  // R6: each bank drive follows only its own request
  assert_bank_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive.b1 == !oe1b_n) && (drive.b2 == !oe2b_n));

endmodule

// File: rtl/bx_exchange.sv
module bx_exchange
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         le1b,
  input  logic         le2b,
  input  logic         lea1b,
  input  logic         lea2b,
  input  logic         oea_n,
  input  logic         oe1b_n,
  input  logic         oe2b_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe,
  output logic         clash
);

  logic [W-1:0] a_val;
  logic [W-1:0] b1_val;
  logic [W-1:0] b2_val;
  bx_drive_t    drive;
  bx_dir_e      dir;
  logic         is_clash;

  bx_b2a_path #(.W(W)) u_b2a (
    .clk(clk), .rst_n(rst_n), .sel(sel), .le1b(le1b), .le2b(le2b),
    .b1_in(b1_in), .b2_in(b2_in), .a_val(a_val)
  );

  bx_a2b_path #(.W(W)) u_a2b (
    .clk(clk), .rst_n(rst_n), .lea1b(lea1b), .lea2b(lea2b),
    .a_in(a_in), .b1_val(b1_val), .b2_val(b2_val)
  );

  bx_oe_ctrl u_oe (
    .clk(clk), .rst_n(rst_n), .oea_n(oea_n), .oe1b_n(oe1b_n),
    .oe2b_n(oe2b_n), .drive(drive), .dir(dir)
  );

  assign is_clash = (dir == DIR_CLASH);

  assign a_oe   = drive.a;
  assign b1_oe  = drive.b1;
  assign b2_oe  = drive.b2;
  assign clash  = is_clash;
  assign a_out  = is_clash ? 'x : a_val;
  assign b1_out = is_clash ? 'x : b1_val;
  assign b2_out = is_clash ? 'x : b2_val;

  // R7: a clash can only be flagged when A and a bank both drive
  assert_clash_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (a_oe && (b1_oe || b2_oe)));

  // R5: A drive follows its active-low request once out of reset
  assert_a_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe == !oea_n);

endmodule

// File: tb/bx_exchange_bench.sv
module bx_exchange_bench;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b0, le1b = 1'b0, le2b = 1'b0, lea1b = 1'b0, lea2b = 1'b0;
  logic         oea_n = 1'b1, oe1b_n = 1'b1, oe2b_n = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe, clash;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench-side storage
  logic [W-1:0] m1a = '0, m2a = '0, ma1 = '0, ma2 = '0;

  always #4 clk = ~clk;

  bx_exchange #(.W(W)) u_bx_exchange (
    .clk(clk), .rst_n(rst_n), .sel(sel), .le1b(le1b), .le2b(le2b),
    .lea1b(lea1b), .lea2b(lea2b), .oea_n(oea_n), .oe1b_n(oe1b_n),
    .oe2b_n(oe2b_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe), .b2_in(b2_in),
    .b2_out(b2_out), .b2_oe(b2_oe), .clash(clash)
  );

  function automatic logic [W-1:0] see(input logic open, input logic [W-1:0] pin,
                                       input logic [W-1:0] kept);
    return open ? pin : kept;
  endfunction

  function automatic logic exp_clash(input logic an, input logic n1, input logic n2);
    return (an == 1'b0) && ((n1 == 1'b0) || (n2 == 1'b0));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic cl;
    logic [W-1:0] ea;
    cl = exp_clash(oea_n, oe1b_n, oe2b_n);
    chk(a_oe  === ~oea_n,  "R5 a_oe",  {{(W-1){1'b0}}, a_oe},  {{(W-1){1'b0}}, ~oea_n});
    chk(b1_oe === ~oe1b_n, "R6 b1_oe", {{(W-1){1'b0}}, b1_oe}, {{(W-1){1'b0}}, ~oe1b_n});
    chk(b2_oe === ~oe2b_n, "R6 b2_oe", {{(W-1){1'b0}}, b2_oe}, {{(W-1){1'b0}}, ~oe2b_n});
    chk(clash === cl,      "R7 clash", {{(W-1){1'b0}}, clash}, {{(W-1){1'b0}}, cl});
    if (!cl) begin
      ea = sel ? see(le1b, b1_in, m1a) : see(le2b, b2_in, m2a);
      if (a_oe)  chk(a_out === ea, "R3 a_out", a_out, ea);
      if (b1_oe) chk(b1_out === see(lea1b, a_in, ma1), "R4 b1_out", b1_out,
                     see(lea1b, a_in, ma1));
      if (b2_oe) chk(b2_out === see(lea2b, a_in, ma2), "R4 b2_out", b2_out,
                     see(lea2b, a_in, ma2));
    end
  endtask

  // inputs already applied after the falling edge; check, then cross the edge
  task automatic settle();
    #2;
    compare_all();
    @(posedge clk);
    if (le1b)  m1a = b1_in;
    if (le2b)  m2a = b2_in;
    if (lea1b) ma1 = a_in;
    if (lea2b) ma2 = a_in;
    @(negedge clk);
  endtask

  task automatic ctl(input logic s, input logic l1, input logic l2, input logic la1,
                     input logic la2, input logic an, input logic n1, input logic n2);
    sel = s; le1b = l1; le2b = l2; lea1b = la1; lea2b = la2;
    oea_n = an; oe1b_n = n1; oe2b_n = n2;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd5150);
    // R1: reset with every request active and every latch open
    ctl(1, 1, 1, 1, 1, 0, 0, 0);
    a_in = 12'h5A5; b1_in = 12'h3C3; b2_in = 12'h0F0;
    repeat (3) @(negedge clk);
    #2;
    chk({a_oe, b1_oe, b2_oe, clash} === 4'b0000, "R1 reset float",
        {8'h0, a_oe, b1_oe, b2_oe, clash}, '0);
    @(negedge clk);
    ctl(1, 0, 0, 0, 0, 1, 1, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: cleared latches read zero
    ctl(1, 0, 0, 0, 0, 0, 1, 1);
    #2; chk(a_out === '0, "R1 cleared 1B latch", a_out, '0);
    sel = 0; #1; chk(a_out === '0, "R1 cleared 2B latch", a_out, '0);
    @(negedge clk);
    ctl(0, 0, 0, 0, 0, 1, 0, 0);
    #2; chk(b1_out === '0 && b2_out === '0, "R1 cleared A latches", b1_out | b2_out, '0);
    @(negedge clk);

    // R2/R3: capture through B1 latch, then hold while the pins keep moving
    ctl(1, 1, 0, 0, 0, 0, 1, 1); b1_in = 12'hABC; settle();
    ctl(1, 0, 0, 0, 0, 0, 1, 1); b1_in = 12'h123; settle();
    b1_in = 12'h777; #2;
    chk(a_out === 12'hABC, "R2 hold while input changes", a_out, 12'hABC);
    @(negedge clk);
    // R3: switch to B2 side
    ctl(0, 0, 1, 0, 0, 0, 1, 1); b2_in = 12'h456; settle();
    ctl(0, 0, 0, 0, 0, 0, 1, 1); b2_in = 12'hFFF; settle();
    sel = 1; #2;
    chk(a_out === 12'hABC, "R3 select back to 1B", a_out, 12'hABC);
    @(negedge clk);

    // R4: interleave address into B1 and data into B2
    ctl(1, 0, 0, 1, 0, 1, 0, 0); a_in = 12'h100; settle();
    ctl(1, 0, 0, 0, 1, 1, 0, 0); a_in = 12'h2D2; settle();
    ctl(1, 0, 0, 0, 0, 1, 0, 0); a_in = 12'hEEE; #2;
    chk(b1_out === 12'h100, "R4 bank1 address", b1_out, 12'h100);
    chk(b2_out === 12'h2D2, "R4 bank2 data", b2_out, 12'h2D2);
    @(negedge clk);

    // R6: each bank alone
    ctl(1, 0, 0, 0, 0, 1, 0, 1); settle();
    ctl(1, 0, 0, 0, 0, 1, 1, 0); settle();
    ctl(1, 0, 0, 0, 0, 1, 1, 1); settle();

    // R8: storage survives a disabled spell, capture while disabled too
    ctl(1, 0, 0, 1, 0, 1, 1, 1); a_in = 12'h9A9; settle();
    ctl(1, 0, 0, 0, 0, 1, 0, 1); a_in = 12'h000; #2;
    chk(b1_out === 12'h9A9, "R8 captured while disabled", b1_out, 12'h9A9);
    @(negedge clk);

    // R7: deliberate clash
    ctl(1, 0, 0, 0, 0, 0, 0, 1); #2;
    chk(clash === 1'b1, "R7 clash raised", {11'h0, clash}, 12'h1);
    @(negedge clk);
    ctl(1, 0, 0, 0, 0, 1, 1, 1); settle();

    // random phase
    for (int i = 0; i < 2000; i++) begin
      logic an;
      an = ($urandom % 2) == 0;
      ctl($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
          an,
          an ? ($urandom % 2) : (($urandom % 10) != 0),
          an ? ($urandom % 2) : (($urandom % 10) != 0));
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      settle();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule